// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Controller

This block watches a set of already synchronized input pins, grouped into byte-wide banks, and raises an active-low interrupt when any pin that is set as an input and not masked holds a level different from what the host last saw. Each bank keeps a snapshot register. It records the pin levels at the moment the host read that bank's input register. The host signals each read with a one-cycle strobe per bank.

Direction and mask values come from registers outside this block. The interrupt is the OR of all per-bank mismatches, registered once. It clears in two ways. The first is when the host has read every bank that holds a changed bit. The second is when the changed pins return to their snapshot levels without any read. On the first clock after reset, every snapshot takes the current pin levels, so startup does not produce an interrupt.

Top module: `mcirq_top`

## Requirements
- R1: `irq_n_o` is 1 during reset and on the first sample after reset. This holds even when the pins are nonzero at reset release, because every snapshot is loaded with the live pins on the first clock after reset.
- R2: A pin whose mask bit is 1 never causes an interrupt, whatever its level.
- R3: A pin whose direction bit is 0 (output) never causes an interrupt. Direction bit 1 means input.
- R4: When an unmasked input pin differs from its bank snapshot at a clock edge, `irq_n_o` reads 0 after that edge. The output is registered, so it is one cycle behind the comparison.
- R5: If every differing unmasked input returns to its snapshot level, `irq_n_o` returns to 1 one cycle later, with no read needed.
- R6: `bank_rd_i[b]` loads pins `8*b+7 .. 8*b` into snapshot b at the clock edge. This removes only bank b's contribution, and mismatches in other banks keep the interrupt asserted.
- R7: If changes sit in several banks, `irq_n_o` stays 0 until each of those banks has been read. It returns to 1 one cycle after the last of those reads.
- R8: Changing a pin's direction bit from 0 to 1 while its level differs from the snapshot raises the interrupt, provided the pin is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 40 | Synchronized pin levels; bit 8*b+j is bit j of bank b |
| dir_in_i | input | 40 | Per-pin direction, 1 = input, 0 = output |
| mask_i | input | 40 | Per-pin interrupt mask, 1 = suppressed |
| bank_rd_i | input | 5 | One-cycle strobe per bank marking a host read of its input register |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Several properties are checked on every cycle:
- A bank with every pin masked or set as output reports no mismatch.
- A bank read leaves no mismatch in that bank unless the pins move.
- Pending state holds until a read or an input or configuration change.
- The registered output follows the OR of the bank mismatches, and stays quiet right after the startup load.

Only the bench scenarios show the history-dependent behaviour: multi-bank changes needing a read of every bank, clearing when inputs return to their snapshot levels, and the false interrupt when a pin changes from output to input.

// File: rtl/mcirq_pkg.sv
package mcirq_pkg;
  localparam int BANK_W = 8;

  // Set when any unmasked input bit of a bank differs from its snapshot
  function automatic logic bank_hit(input logic [BANK_W-1:0] live,
                                    input logic [BANK_W-1:0] snap,
                                    input logic [BANK_W-1:0] in_dir,
                                    input logic [BANK_W-1:0] msk);
    return |((live ^ snap) & in_dir & ~msk);
  endfunction
endpackage

// File: rtl/mcirq_bank.sv
module mcirq_bank
  import mcirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              rd,
  input  logic [BANK_W-1:0] live,
  input  logic [BANK_W-1:0] in_dir,
  input  logic [BANK_W-1:0] msk,
  output logic              pending
);
  logic [BANK_W-1:0] snap_q;
  logic              load_now;

  // Load on the startup pass or on a host read of this bank
  assign load_now = !armed || rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (load_now) snap_q <= live;
  end

  assign pending = armed && bank_hit(live, snap_q, in_dir, msk);

  // R2/R3: a bank with no armed input pin reports nothing
  p_no_armed_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&(msk | ~in_dir)) |-> !pending);

  // R6: after a read the bank is clean unless its pins or config moved
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && armed) |=> (!pending || !$stable(live) || !$stable(in_dir) || !$stable(msk)));

  // R7: without a read or a change, pending state holds
  p_hold_until_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rd) |=> (!$stable(live) || !$stable(in_dir) || !$stable(msk) || $stable(pending)));
endmodule

// File: rtl/mcirq_merge.sv
module mcirq_merge #(
  parameter int NUM_BANKS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 armed,
  input  logic [NUM_BANKS-1:0] pend,
  output logic                 irq_n
);
  logic any_pend;
  assign any_pend = armed && (|pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~any_pend;
  end

  // R4: a pending bank shows on the output one cycle later
  p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && |pend) |=> !irq_n);

  // R5: no pending bank means the output releases one cycle later
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |=> irq_n);
endmodule

// File: rtl/mcirq_top.sv
module mcirq_top
  import mcirq_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  localparam int NPINS    = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     pins_i,
  input  logic [NPINS-1:0]     dir_in_i,
  input  logic [NPINS-1:0]     mask_i,
  input  logic [NUM_BANKS-1:0] bank_rd_i,
  output logic                 irq_n_o
);
  logic                 armed_q;
  logic [NUM_BANKS-1:0] bank_pend;

  // First clock after reset is the snapshot load pass
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    mcirq_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (armed_q),
      .rd      (bank_rd_i[b]),
      .live    (pins_i[b*BANK_W +: BANK_W]),
      .in_dir  (dir_in_i[b*BANK_W +: BANK_W]),
      .msk     (mask_i[b*BANK_W +: BANK_W]),
      .pending (bank_pend[b])
    );
  end

  mcirq_merge #(.NUM_BANKS(NUM_BANKS)) u_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed_q),
    .pend  (bank_pend),
    .irq_n (irq_n_o)
  );

  // R1: the startup load pass never leads to an interrupt
  p_startup_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> irq_n_o);
endmodule

// File: tb/sim_mcirq_top.sv
module sim_mcirq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int NP = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = 40'hA53C0FF011;
  logic [NP-1:0] dir  = '1;
  logic [NP-1:0] msk  = '1;
  logic [NB-1:0] rd   = '0;
  logic          irq_n;

  int n_tests = 0;
  int n_fail  = 0;

  logic [NP-1:0] m_snap;
  logic          m_init;
  logic          m_irq_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcirq_top u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .dir_in_i(dir),
    .mask_i(msk), .bank_rd_i(rd), .irq_n_o(irq_n)
  );

  // Expected pending from the requirement text: unmasked input differing from snapshot
  function automatic logic exp_pending(input logic [NP-1:0] p, s, d, m);
    logic hit = 1'b0;
    for (int i = 0; i < NP; i++)
      if (d[i] && !m[i] && (p[i] != s[i])) hit = 1'b1;
    return hit;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s irq_n actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge, advance model at posedge, compare at next negedge
  task automatic step(input string tag, input logic [NP-1:0] p,
                      input logic [NP-1:0] d, input logic [NP-1:0] m,
                      input logic [NB-1:0] r);
    pins = p; dir = d; msk = m; rd = r;
    @(posedge clk);
    if (!m_init) begin
      m_snap  = p;
      m_init  = 1'b1;
      m_irq_n = 1'b1;
    end else begin
      m_irq_n = ~exp_pending(p, m_snap, d, m);
      for (int b = 0; b < NB; b++)
        if (r[b]) m_snap[b*8 +: 8] = p[b*8 +: 8];
    end
    @(negedge clk);
    check(tag, irq_n, m_irq_n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NP-1:0] p;
    logic [NP-1:0] d;
    logic [NP-1:0] m;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    m_init = 1'b0; m_irq_n = 1'b1; m_snap = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", irq_n, 1'b1);
    rst_n = 1'b1;
    p = pins; d = '1; m = '0;
    // R1: unmasked and nonzero pins, yet startup load keeps quiet
    step("R1 first sample", p, d, m, '0);
    check("R1 explicit", irq_n, 1'b1);
    step("R1 idle", p, d, m, '0);
    // R2: masked pin toggling
    m = '1;
    p[3] = ~p[3];
    step("R2 masked change", p, d, m, '0);
    check("R2 explicit", irq_n, 1'b1);
    step("R2 read bank0", p, d, m, 5'b00001);
    // R3: outputs toggling, unmasked
    m = '0; d = '0;
    p = p ^ 40'hFF_0000_00FF;
    step("R3 output change", p, d, m, '0);
    check("R3 explicit", irq_n, 1'b1);
    // R8: output to input with mismatching level
    d = '1;
    step("R8 dir switch", p, d, m, '0);
    step("R8 asserted", p, d, m, '0);
    check("R8 explicit", irq_n, 1'b0);
    step("R6 read all", p, d, m, 5'b11111);
    step("R6 cleared", p, d, m, '0);
    check("R6 explicit", irq_n, 1'b1);
    // R4 then R5: change and return
    p[10] = ~p[10];
    step("R4 change", p, d, m, '0);
    check("R4 explicit", irq_n, 1'b0);
    p[10] = ~p[10];
    step("R5 return", p, d, m, '0);
    check("R5 explicit", irq_n, 1'b1);
    // R7: banks 0, 2, 3 change together
    p[5] = ~p[5]; p[19] = ~p[19]; p[31] = ~p[31];
    step("R7 change", p, d, m, '0);
    step("R7 read b0", p, d, m, 5'b00001);
    step("R7 read b2", p, d, m, 5'b00100);
    check("R7 still low", irq_n, 1'b0);
    step("R7 read b3", p, d, m, 5'b01000);
    step("R7 cleared", p, d, m, '0);
    check("R7 explicit", irq_n, 1'b1);
    // R6: reading an unchanged bank leaves another bank pending
    p[33] = ~p[33];
    step("R6 change b4", p, d, m, '0);
    step("R6 read b1", p, d, m, 5'b00010);
    step("R6 b4 pending", p, d, m, '0);
    check("R6 other bank", irq_n, 1'b0);
    step("R6 read b4", p, d, m, 5'b10000);
    // Random phase against the model (R4, R5, R6 general)
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) p[$urandom_range(0, NP-1)] ^= 1'b1;
      if ($urandom_range(0, 19) == 0) d = {$urandom, $urandom} | {$urandom, $urandom};
      if ($urandom_range(0, 19) == 0) m = {$urandom, $urandom} & {$urandom, $urandom};
      step("R4 random", p, d, m, ($urandom_range(0, 2) == 0) ? NB'($urandom) : '0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule